// File: doc/BRIEF.md
# Outbound Windowed Address Translator

This block sits on the outbound path between a system bus master and a PCI-side unit. It rewrites each outbound address that lands in a 128 MB region. That region is divided into eight windows of 16 MB each, and every window has a 32-bit offset that software can program. For an address inside the region, the three bits just above the 16 MB boundary choose a window. The low 24 bits are kept, and the chosen window's offset is added to them to form the downstream address.

Some addresses pass through unchanged and are not flagged as PCI traffic: outbound addresses outside the region, and every inbound address (one mastered by the PCI device). The four top address bits take no part in the decision.

Each request is a single cycle with `in_valid` high. Its result appears one clock later on a registered output stage, marked by `out_valid` and a per-request `out_pci` flag. A small indexed port writes the offsets and reads them back.

Top module: `owx_top`

## Requirements
- R1: After reset every window offset reads as zero and `out_valid` is low.
- R2: A write to index 0 to 7 stores `reg_wdata` in that window, and a read of that index then returns it.
- R3: Indices 8 to 15 always read as zero, and writes to them change no window offset.
- R4: An outbound request with address bit 27 = 0 gives `out_pci` = 1. Its `out_addr` equals `in_addr[23:0]` (zero-extended) plus the offset of window `in_addr[26:24]`. Bits [31:28] have no effect on the result.
- R5: The addition wraps modulo 2^32, and there is no carry output.
- R6: An outbound request with address bit 27 = 1 gives `out_pci` = 0 and `out_addr` equal to `in_addr` unchanged.
- R7: An inbound request (`in_inbound` = 1) gives `out_pci` = 0 and `out_addr` equal to `in_addr` unchanged, whatever the value of bit 27.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While no request arrives, `out_addr` and `out_pci` hold their last values.
- R9: A request in the same cycle as an offset write uses the old offset. A request in the next cycle uses the new one.
- R10: With window 0 set to 0x10000000, input 0x100000FF yields 0x100000FF. With window 2 set to 0x12000000, input 0x120000FF yields 0x120000FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| in_inbound | input | 1 | 1 = inbound request, passed through untranslated |
| in_addr | input | 32 | Request address |
| out_valid | output | 1 | Registered result is valid |
| out_pci | output | 1 | Result was translated into the PCI region |
| out_addr | output | 32 | Registered downstream address |
| reg_we | input | 1 | Offset write strobe |
| reg_idx | input | 4 | Window index for write and read |
| reg_wdata | input | 32 | Offset write data |
| reg_rdata | output | 32 | Offset read data (combinational) |

## Verification
A corrupted offset register shows up in two places at once: in the readback on `reg_rdata`, and as a fixed error on `out_addr` one cycle after any request to that window. A sweep over every window with several in-window addresses will therefore expose it. A wrong window index or a bad region test shows up on the first request whose bits [26:24] or bit 27 differ, as a wrong address or a flipped `out_pci`. A slipped pipeline stage shows up on `out_valid` in the first idle cycle. The cycle of a simultaneous write and request exposes any bypass that skips the one-cycle write latency.

// File: rtl/owx_pkg.sv
package owx_pkg;
  localparam int OWX_ADDR_W   = 32;
  localparam int OWX_WIN_LOG2 = 24;
  localparam int OWX_NUM_WIN  = 8;
  localparam int OWX_IDX_W    = 4;

  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_XLATE   = 2'd1,
    KIND_PASS_HI = 2'd2,
    KIND_PASS_IN = 2'd3
  } owx_kind_e;
endpackage

// File: rtl/owx_winregs.sv
module owx_winregs #(
  parameter int NUM_WIN = owx_pkg::OWX_NUM_WIN,
  parameter int IDX_W   = owx_pkg::OWX_IDX_W,
  parameter int OFF_W   = owx_pkg::OWX_ADDR_W,
  localparam int SEL_W  = $clog2(NUM_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [OFF_W-1:0] wdata,
  output logic [OFF_W-1:0] rdata,
  input  logic [SEL_W-1:0] sel,
  output logic [OFF_W-1:0] sel_off,
  output logic             wr_hit
);
  localparam logic [IDX_W:0] NUM_WIN_L = NUM_WIN[IDX_W:0];

  logic [OFF_W-1:0] off_q [NUM_WIN];
  logic             idx_in_range;
  logic [SEL_W-1:0] idx_sel;

  assign idx_in_range = ({1'b0, idx} < NUM_WIN_L);
  assign idx_sel      = idx[SEL_W-1:0];
  assign wr_hit       = we && idx_in_range;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic hit;
    assign hit = wr_hit && (idx_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   off_q[g] <= '0;
      else if (hit) off_q[g] <= wdata;
    end
  end

  assign rdata   = idx_in_range ? off_q[idx_sel] : '0;
  assign sel_off = off_q[sel];
endmodule

// File: rtl/owx_decode.sv
module owx_decode #(
  parameter int ADDR_W   = owx_pkg::OWX_ADDR_W,
  parameter int WIN_LOG2 = owx_pkg::OWX_WIN_LOG2,
  parameter int NUM_WIN  = owx_pkg::OWX_NUM_WIN,
  localparam int SEL_W   = $clog2(NUM_WIN),
  localparam int REGION_BIT = WIN_LOG2 + SEL_W
) (
  input  logic                 in_valid,
  input  logic                 in_inbound,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [ADDR_W-1:0]    sel_off,
  output logic [SEL_W-1:0]     sel,
  output owx_pkg::owx_kind_e   kind,
  output logic [ADDR_W-1:0]    nxt_addr
);
  import owx_pkg::*;

  function automatic logic [ADDR_W-1:0] in_window(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[WIN_LOG2-1:0] = a[WIN_LOG2-1:0];
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] window_sum(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] off);
    return in_window(a) + off;
  endfunction

  logic outside_region;

  assign sel            = in_addr[REGION_BIT-1:WIN_LOG2];
  assign outside_region = in_addr[REGION_BIT];

  always_comb begin
    if (!in_valid)           kind = KIND_NONE;
    else if (in_inbound)     kind = KIND_PASS_IN;
    else if (outside_region) kind = KIND_PASS_HI;
    else                     kind = KIND_XLATE;
  end

  always_comb begin
    if (kind == KIND_XLATE) nxt_addr = window_sum(in_addr, sel_off);
    else                    nxt_addr = in_addr;
  end
endmodule

// File: rtl/owx_outreg.sv
module owx_outreg #(
  parameter int ADDR_W = owx_pkg::OWX_ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  owx_pkg::owx_kind_e kind,
  input  logic [ADDR_W-1:0]  nxt_addr,
  output logic               out_valid,
  output logic               out_pci,
  output logic [ADDR_W-1:0]  out_addr
);
  import owx_pkg::*;

  logic take;
  assign take = (kind != KIND_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pci   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_pci  <= (kind == KIND_XLATE);
        out_addr <= nxt_addr;
      end
    end
  end
endmodule

// File: rtl/owx_top.sv
module owx_top #(
  parameter int ADDR_W   = owx_pkg::OWX_ADDR_W,
  parameter int WIN_LOG2 = owx_pkg::OWX_WIN_LOG2,
  parameter int NUM_WIN  = owx_pkg::OWX_NUM_WIN,
  parameter int IDX_W    = owx_pkg::OWX_IDX_W,
  localparam int SEL_W   = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_inbound,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic              out_pci,
  output logic [ADDR_W-1:0] out_addr,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata
);
  logic [SEL_W-1:0]   sel;
  logic [ADDR_W-1:0]  sel_off;
  logic               wr_hit;
  owx_pkg::owx_kind_e kind;
  logic [ADDR_W-1:0]  nxt_addr;

  owx_winregs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .OFF_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .sel(sel), .sel_off(sel_off), .wr_hit(wr_hit)
  );

  owx_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NUM_WIN(NUM_WIN)) u_dec (
    .in_valid(in_valid), .in_inbound(in_inbound), .in_addr(in_addr),
    .sel_off(sel_off), .sel(sel), .kind(kind), .nxt_addr(nxt_addr)
  );

  owx_outreg #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .kind(kind), .nxt_addr(nxt_addr),
    .out_valid(out_valid), .out_pci(out_pci), .out_addr(out_addr)
  );
endmodule

// File: rtl/owx_checker.sv
module owx_checker #(
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 24,
  parameter int NUM_WIN  = 8,
  parameter int IDX_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_inbound,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic              out_pci,
  input logic [ADDR_W-1:0] out_addr,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic [ADDR_W-1:0] sel_off
);
  localparam int REGION_BIT = WIN_LOG2 + $clog2(NUM_WIN);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << WIN_LOG2) - 64'd1);
  localparam logic [IDX_W:0] NUM_WIN_L = NUM_WIN[IDX_W:0];

  // R8: a valid result follows each request by one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4, R5: in-region outbound address is low bits plus window offset
  a_r4_translate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_inbound && !in_addr[REGION_BIT]) |=>
      (out_pci && out_addr == (($past(in_addr) & LOW_MASK) + $past(sel_off))));

  // R6: out-of-region outbound address passes unchanged
  a_r6_pass_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_inbound && in_addr[REGION_BIT]) |=>
      (!out_pci && out_addr == $past(in_addr)));

  // R7: inbound address passes unchanged
  a_r7_pass_inbound: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_inbound) |=> (!out_pci && out_addr == $past(in_addr)));

  // R3: indices past the last window read as zero
  a_r3_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, reg_idx} >= NUM_WIN_L) |-> (reg_rdata == '0));
endmodule

bind owx_top owx_checker #(
  .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inbound(in_inbound),
  .in_addr(in_addr), .out_valid(out_valid), .out_pci(out_pci),
  .out_addr(out_addr), .reg_idx(reg_idx), .reg_rdata(reg_rdata),
  .sel_off(sel_off)
);

// File: tb/owx_top_test.sv
`timescale 1ns/1ps
module owx_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_inbound;
  logic [31:0] in_addr;
  logic        out_valid, out_pci;
  logic [31:0] out_addr;
  logic        reg_we;
  logic [3:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] model [8];

  always #2 clk = ~clk;

  owx_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inbound(in_inbound),
    .in_addr(in_addr), .out_valid(out_valid), .out_pci(out_pci),
    .out_addr(out_addr), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_xlate(input logic [31:0] a);
    return (a % 32'h0100_0000) + model[(a / 32'h0100_0000) % 8];
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (idx < 8) model[idx[2:0]] = d;
  endtask

  task automatic rd_check(input logic [3:0] idx, input logic [31:0] exp, input string req);
    reg_idx = idx;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // one request; the result is read at the following negedge
  task automatic req(input logic [31:0] a, input bit inb, input bit exp_pci,
                     input logic [31:0] exp, input string tag);
    in_valid = 1'b1; in_inbound = inb; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && (out_pci == exp_pci) && (out_addr == exp), tag, out_addr, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_inbound = 1'b0; in_addr = '0;
    reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'd0);
    for (int i = 0; i < 8; i++) rd_check(4'(i), 32'd0, "R1 offset zero");

    // R10: worked examples
    wr(4'd0, 32'h1000_0000);
    wr(4'd2, 32'h1200_0000);
    req(32'h1000_00FF, 1'b0, 1'b1, 32'h1000_00FF, "R10 window0");
    req(32'h1200_00FF, 1'b0, 1'b1, 32'h1200_00FF, "R10 window2");

    // R2: write and read back every window
    for (int i = 0; i < 8; i++) wr(4'(i), 32'h2000_0000 + 32'(i) * 32'h0111_0010);
    for (int i = 0; i < 8; i++) rd_check(4'(i), model[i], "R2 readback");

    // R3: out-of-range indices
    for (int i = 8; i < 16; i++) wr(4'(i), 32'hDEAD_0000 + 32'(i));
    for (int i = 8; i < 16; i++) rd_check(4'(i), 32'd0, "R3 reads zero");
    for (int i = 0; i < 8; i++) rd_check(4'(i), model[i], "R3 window untouched");

    // R4: sweep windows, upper nibble and in-window addresses
    for (int w = 0; w < 8; w++) begin
      for (int hi = 0; hi < 16; hi++) begin
        for (int k = 0; k < 4; k++) begin
          logic [23:0] lo;
          logic [31:0] a;
          lo = (k == 0) ? 24'h000000 : (k == 1) ? 24'hFFFFFF :
               (k == 2) ? 24'h123456 : 24'(w * 32'h10101);
          a = {4'(hi), 1'b0, 3'(w), lo};
          req(a, 1'b0, 1'b1, expect_xlate(a), "R4 translate");
        end
      end
    end

    // R5: wrap-around of the sum
    wr(4'd5, 32'hFFFF_FF00);
    req(32'h0500_0200, 1'b0, 1'b1, 32'h0000_0100, "R5 wrap");
    req(32'hF5FF_FFFF, 1'b0, 1'b1, 32'h00FF_FEFF, "R5 wrap high");

    // R6: outside the region passes through
    for (int w = 0; w < 8; w++) begin
      logic [31:0] a;
      a = {4'(w * 2 + 1), 1'b1, 3'(w), 24'hA5A5A5};
      req(a, 1'b0, 1'b0, a, "R6 pass");
    end

    // R7: inbound passes through regardless of bit 27
    req(32'h0300_1234, 1'b1, 1'b0, 32'h0300_1234, "R7 inbound low");
    req(32'h1B00_1234, 1'b1, 1'b0, 32'h1B00_1234, "R7 inbound high");

    // R8: idle cycle drops valid and holds the address
    @(negedge clk);
    check(out_valid == 1'b0, "R8 idle valid", {31'd0, out_valid}, 32'd0);
    check(out_addr == 32'h1B00_1234, "R8 hold addr", out_addr, 32'h1B00_1234);

    // R9: same-cycle write uses old offset, next cycle the new one
    wr(4'd3, 32'h0000_1000);
    reg_we = 1'b1; reg_idx = 4'd3; reg_wdata = 32'h4000_0000;
    in_valid = 1'b1; in_inbound = 1'b0; in_addr = 32'h0300_0010;
    @(negedge clk);
    reg_we = 1'b0;
    check(out_valid && out_addr == 32'h0000_1010, "R9 old offset", out_addr, 32'h0000_1010);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_addr == 32'h4000_0010, "R9 new offset", out_addr, 32'h4000_0010);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule